// File: doc/BRIEF.md
# Packed Saturating Lane Adder

This block is a registered lane-parallel arithmetic unit. It works on a 32-bit word. The word is split into four 8-bit lanes, two 16-bit lanes or one 32-bit lane, and each lane is read as either a signed or an unsigned number. It supports five operations: add, subtract, absolute value, halving add and halving subtract. Add, subtract and absolute value either saturate at the bounds of the lane type or wrap modulo the lane width. The halving operations keep one extra bit of precision and can round up before the final shift.

When an add, subtract or absolute value overflows in any active lane, a sticky flag is set in a 32-bit status word. Once set, the flag stays set until reset, so software can run a whole loop of lane operations and test a single bit at the end. The caller presents the operands and the mode selects together with a valid strobe. The result and the updated status appear on the outputs after the next rising clock edge.

Top module: `simd_addsub`

## Requirements
- R1: `lane_i` selects the partition: 0 gives four 8-bit lanes, 1 gives two 16-bit lanes, and 2 or 3 gives one 32-bit lane. Lane k occupies bits [k*w+w-1 : k*w]. No carry, borrow or rounding bit passes from one lane to the next.
- R2: In a signed add, a lane overflows when both operands have the same sign and the sum's sign differs from theirs. In a signed subtract, a lane overflows when the operand signs differ and the difference's sign differs from the first operand's sign. With `sat_i`=1, an overflowing lane becomes the largest positive code if the first operand is non-negative, and the most negative code otherwise.
- R3: In an unsigned add, a carry out of a lane is an overflow; with `sat_i`=1 that lane becomes all ones. In an unsigned subtract, a borrow is an overflow; with `sat_i`=1 that lane becomes zero.
- R4: With `sat_i`=0, an overflowing add or subtract returns the low w bits of the exact result in the lane, and the overflow still sets the sticky flag.
- R5: Absolute value reads every lane as signed, whatever `signed_i` is, and ignores `b_i`. The most negative code overflows: with `sat_i`=1 it gives the largest positive code, and with `sat_i`=0 it gives the same code back. Both cases set the sticky flag.
- R6: Any lane overflow in an accepted operation sets `status_o[20]`. That bit stays set until reset. Every other status bit reads zero.
- R7: Halving operations form the exact sum or difference, add `round_i` (0 or 1), and return bits [w:1] of the result, sign-extended when signed and zero-extended when unsigned. They never change the status.
- R8: `op_i` encoding: 0 = add, 1 = subtract, 2 = absolute value, 3 = halving add, 4 = halving subtract. Codes 5 to 7 return zero and never change the status.
- R9: With `valid_i`=1, the result and status are written on the rising clock edge. With `valid_i`=0, both hold their values. A synchronous `rst` clears both to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| valid_i | input | 1 | Accept the operation this cycle |
| op_i | input | 3 | Operation code (R8) |
| lane_i | input | 2 | Lane partition select (R1) |
| signed_i | input | 1 | Read lanes as signed |
| sat_i | input | 1 | Saturate on overflow instead of wrapping |
| round_i | input | 1 | Add one before the halving shift |
| a_i | input | 32 | First operand |
| b_i | input | 32 | Second operand |
| result_o | output | 32 | Registered result word |
| status_o | output | 32 | Status word, sticky overflow at bit 20 |

## Verification
There are two registers. A wrong result register shows up on `result_o` in the cycle after the operation is accepted. A sticky bit that is dropped, or set when it should not be, shows up on `status_o[20]` one cycle after the operation that caused it. Because the flag is sticky, a single wrong set corrupts every later status comparison until the next reset.

The reference model is compared with the outputs on every clock. It is driven as follows:
- Early stimulus holds non-overflowing and flag-free operations (halving, undefined codes) before the first overflow, so a flag that is set by mistake is seen at once.
- A reset in the middle of the run confirms that both registers clear.

// File: rtl/simd_pkg.sv
package simd_pkg;

    localparam logic [2:0] OP_ADD  = 3'd0;
    localparam logic [2:0] OP_SUB  = 3'd1;
    localparam logic [2:0] OP_ABS  = 3'd2;
    localparam logic [2:0] OP_HADD = 3'd3;
    localparam logic [2:0] OP_HSUB = 3'd4;

    typedef enum logic [1:0] {
        PART_BYTE = 2'd0,
        PART_HALF = 2'd1,
        PART_WORD = 2'd2
    } part_e;

    typedef struct packed {
        logic [2:0] op;
        logic       sgn;
        logic       sat;
        logic       rnd;
    } lane_ctl_t;

    function automatic part_e part_of(input logic [1:0] sel);
        case (sel)
            2'd0:    return PART_BYTE;
            2'd1:    return PART_HALF;
            default: return PART_WORD;
        endcase
    endfunction

    function automatic logic is_halving(input logic [2:0] op);
        return (op == OP_HADD) || (op == OP_HSUB);
    endfunction

endpackage

// File: rtl/simd_lane_alu.sv
module simd_lane_alu
    import simd_pkg::*;
#(
    parameter int unsigned W = 8
) (
    input  lane_ctl_t      ctl,
    input  logic [W-1:0]   a,
    input  logic [W-1:0]   b,
    output logic [W-1:0]   res,
    output logic           ovf
);
    localparam int unsigned XW = W + 2;

    logic          ext_a, ext_b;
    logic [XW-1:0] xa, xb, sum, dif, hsum, hdif;
    logic [W-1:0]  smax, smin, wrap_val, clamp_val, mag;

    always_comb begin
        ext_a = ctl.sgn & a[W-1];
        ext_b = ctl.sgn & b[W-1];
        xa    = {ext_a, ext_a, a};
        xb    = {ext_b, ext_b, b};
        sum   = xa + xb;
        dif   = xa - xb;
        hsum  = sum + {{(XW-1){1'b0}}, ctl.rnd};
        hdif  = dif + {{(XW-1){1'b0}}, ctl.rnd};
        smax  = {1'b0, {(W-1){1'b1}}};
        smin  = {1'b1, {(W-1){1'b0}}};
        mag   = a[W-1] ? (~a + 1'b1) : a;

        ovf       = 1'b0;
        wrap_val  = '0;
        clamp_val = '0;
        case (ctl.op)
            OP_ADD: begin
                wrap_val = sum[W-1:0];
                if (ctl.sgn) begin
                    ovf       = (a[W-1] == b[W-1]) && (sum[W-1] != a[W-1]);
                    clamp_val = a[W-1] ? smin : smax;
                end else begin
                    ovf       = sum[W];
                    clamp_val = '1;
                end
            end
            OP_SUB: begin
                wrap_val = dif[W-1:0];
                if (ctl.sgn) begin
                    ovf       = (a[W-1] != b[W-1]) && (dif[W-1] != a[W-1]);
                    clamp_val = a[W-1] ? smin : smax;
                end else begin
                    ovf       = dif[W];
                    clamp_val = '0;
                end
            end
            OP_ABS: begin
                wrap_val  = mag;
                ovf       = (a == smin);
                clamp_val = smax;
            end
            OP_HADD: wrap_val = hsum[W:1];
            OP_HSUB: wrap_val = hdif[W:1];
            default: wrap_val = '0;
        endcase
        res = (ovf && ctl.sat) ? clamp_val : wrap_val;
    end
endmodule

// File: rtl/simd_lane_bank.sv
module simd_lane_bank
    import simd_pkg::*;
#(
    parameter int unsigned W      = 8,
    parameter int unsigned WORD_W = 32
) (
    input  lane_ctl_t          ctl,
    input  logic [WORD_W-1:0]  a,
    input  logic [WORD_W-1:0]  b,
    output logic [WORD_W-1:0]  res,
    output logic               ovf_any
);
    localparam int unsigned N = WORD_W / W;

    logic [N-1:0] lane_ovf;

    for (genvar k = 0; k < N; k++) begin : g_lane
        simd_lane_alu #(.W(W)) u_alu (
            .ctl (ctl),
            .a   (a[k*W +: W]),
            .b   (b[k*W +: W]),
            .res (res[k*W +: W]),
            .ovf (lane_ovf[k])
        );
    end

    assign ovf_any = |lane_ovf;
endmodule

// File: rtl/simd_addsub.sv
module simd_addsub
    import simd_pkg::*;
#(
    parameter int unsigned WORD_W     = 32,
    parameter int unsigned STATUS_W   = 32,
    parameter int unsigned STICKY_POS = 20
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                valid_i,
    input  logic [2:0]          op_i,
    input  logic [1:0]          lane_i,
    input  logic                signed_i,
    input  logic                sat_i,
    input  logic                round_i,
    input  logic [WORD_W-1:0]   a_i,
    input  logic [WORD_W-1:0]   b_i,
    output logic [WORD_W-1:0]   result_o,
    output logic [STATUS_W-1:0] status_o
);
    localparam int unsigned NPART = 3;

    lane_ctl_t            ctl;
    logic [WORD_W-1:0]    part_res [NPART];
    logic [NPART-1:0]     part_ovf;
    part_e                part_sel;
    logic [WORD_W-1:0]    result_q;
    logic [STATUS_W-1:0]  status_q;

    assign ctl = '{op: op_i, sgn: signed_i, sat: sat_i, rnd: round_i};

    for (genvar g = 0; g < NPART; g++) begin : g_part
        simd_lane_bank #(.W(8 << g), .WORD_W(WORD_W)) u_bank (
            .ctl     (ctl),
            .a       (a_i),
            .b       (b_i),
            .res     (part_res[g]),
            .ovf_any (part_ovf[g])
        );
    end

    assign part_sel = part_of(lane_i);

    always_ff @(posedge clk) begin
        if (rst) begin
            result_q <= '0;
            status_q <= '0;
        end else if (valid_i) begin
            result_q <= part_res[part_sel];
            if (part_ovf[part_sel])
                status_q[STICKY_POS] <= 1'b1;
        end
    end

    assign result_o = result_q;
    assign status_o = status_q;

    // R6: the overflow flag never clears without reset
    p_sticky_hold_r6: assert property (@(posedge clk) disable iff (rst)
        status_q[STICKY_POS] |=> status_q[STICKY_POS]);

    // R7: halving operations leave status unchanged
    p_halving_quiet_r7: assert property (@(posedge clk) disable iff (rst)
        (valid_i && is_halving(op_i)) |=> (status_q == $past(status_q)));

    // R9: result holds when no operation is accepted
    p_idle_hold_r9: assert property (@(posedge clk) disable iff (rst)
        !valid_i |=> $stable(result_q));

    // R3: unsigned saturating add never falls below the first operand
    p_usat_add_r3: assert property (@(posedge clk) disable iff (rst)
        (valid_i && op_i == OP_ADD && !signed_i && sat_i && lane_i[1])
        |=> (result_q >= $past(a_i)));

    // R3: unsigned saturating subtract never exceeds the first operand
    p_usat_sub_r3: assert property (@(posedge clk) disable iff (rst)
        (valid_i && op_i == OP_SUB && !signed_i && sat_i && lane_i[1])
        |=> (result_q <= $past(a_i)));

    // R5: saturating absolute value of a full word is never negative
    p_abs_nonneg_r5: assert property (@(posedge clk) disable iff (rst)
        (valid_i && op_i == OP_ABS && sat_i && lane_i[1])
        |=> !result_q[WORD_W-1]);

    // R8: undefined codes produce zero
    p_undef_zero_r8: assert property (@(posedge clk) disable iff (rst)
        (valid_i && op_i > OP_HSUB) |=> (result_q == '0));
endmodule

// File: tb/simd_addsub_tb_top.sv
module simd_addsub_tb_top;
    logic        clk = 1'b0;
    logic        rst;
    logic        valid_i;
    logic [2:0]  op_i;
    logic [1:0]  lane_i;
    logic        signed_i, sat_i, round_i;
    logic [31:0] a_i, b_i;
    logic [31:0] result_o, status_o;

    int total = 0;
    int bad   = 0;
    logic [31:0] exp_res;
    logic        exp_flag;

    always #10 clk = ~clk;

    simd_addsub dut_i (
        .clk(clk), .rst(rst), .valid_i(valid_i), .op_i(op_i), .lane_i(lane_i),
        .signed_i(signed_i), .sat_i(sat_i), .round_i(round_i),
        .a_i(a_i), .b_i(b_i), .result_o(result_o), .status_o(status_o)
    );

    function automatic void ref_lane(input int op, input int w, input bit sg,
                                     input bit sat, input bit rnd,
                                     input longint ua, input longint ub,
                                     output longint r, output bit ov);
        longint umax, sa, sb, ta, t, mx, mn, smn;
        umax = (longint'(1) << w) - 1;
        smn  = -(longint'(1) << (w - 1));
        ta   = (ua >= (longint'(1) << (w - 1))) ? ua - (longint'(1) << w) : ua;
        sa   = sg ? ta : ua;
        sb   = (sg && ub >= (longint'(1) << (w - 1))) ? ub - (longint'(1) << w) : ub;
        mx   = sg ? (longint'(1) << (w - 1)) - 1 : umax;
        mn   = sg ? smn : 0;
        ov   = 1'b0;
        r    = 0;
        case (op)
            0, 1: begin
                t  = (op == 0) ? sa + sb : sa - sb;
                ov = (t > mx) || (t < mn);
                r  = (ov && sat) ? ((t > mx) ? mx : mn) : t;
            end
            2: begin
                if (ta == smn) begin
                    ov = 1'b1;
                    r  = sat ? -smn - 1 : ta;
                end else
                    r = (ta < 0) ? -ta : ta;
            end
            3: r = (sa + sb + longint'(rnd)) >>> 1;
            4: r = (sa - sb + longint'(rnd)) >>> 1;
            default: r = 0;
        endcase
        r = r & umax;
    endfunction

    function automatic void ref_word(input int op, input int lane, input bit sg,
                                     input bit sat, input bit rnd,
                                     input logic [31:0] a, input logic [31:0] b,
                                     output logic [31:0] res, output bit ov);
        int w;
        longint r, m;
        bit lo;
        w   = (lane == 0) ? 8 : (lane == 1) ? 16 : 32;
        m   = (longint'(1) << w) - 1;
        res = '0;
        ov  = 1'b0;
        for (int i = 0; i < 32 / w; i++) begin
            ref_lane(op, w, sg, sat, rnd, (longint'(a) >> (i * w)) & m,
                     (longint'(b) >> (i * w)) & m, r, lo);
            res = res | (32'(r) << (i * w));
            ov  = ov | lo;
        end
    endfunction

    task automatic compare(input string tag);
        logic [31:0] exp_stat;
        exp_stat = 32'(exp_flag) << 20;
        total++;
        if (result_o !== exp_res) begin
            bad++;
            $display("FAIL %s result got %h expected %h", tag, result_o, exp_res);
        end
        total++;
        if (status_o !== exp_stat) begin
            bad++;
            $display("FAIL %s status got %h expected %h", tag, status_o, exp_stat);
        end
    endtask

    task automatic step(input bit v, input int op, input int lane, input bit sg,
                        input bit sat, input bit rnd, input logic [31:0] a,
                        input logic [31:0] b, input string tag);
        logic [31:0] r;
        bit ov;
        valid_i = v; op_i = 3'(op); lane_i = 2'(lane);
        signed_i = sg; sat_i = sat; round_i = rnd; a_i = a; b_i = b;
        if (v) begin
            ref_word(op, lane, sg, sat, rnd, a, b, r, ov);
            exp_res  = r;
            exp_flag = exp_flag | ov;
        end
        @(posedge clk);
        @(negedge clk);
        compare(tag);
    endtask

    task automatic do_reset(input string tag);
        rst = 1'b1; valid_i = 1'b0;
        @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        exp_res = '0; exp_flag = 1'b0;
        compare(tag);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        rst = 1'b1; valid_i = 1'b0; op_i = '0; lane_i = '0;
        signed_i = 0; sat_i = 0; round_i = 0; a_i = '0; b_i = '0;
        exp_res = '0; exp_flag = 1'b0;
        @(negedge clk);
        do_reset("R9 reset state");
        // R7 halving, no flag even with large operands
        step(1, 3, 0, 0, 0, 0, 32'hFFFF_FF01, 32'hFF03_FF7F, "R7 hadd u8");
        step(1, 3, 0, 0, 0, 1, 32'hFFFF_FF01, 32'hFF03_FF7F, "R7 hadd u8 rnd");
        step(1, 4, 1, 0, 0, 1, 32'h0001_8000, 32'h0005_7FFF, "R7 hsub u16 rnd");
        step(1, 4, 2, 1, 0, 1, 32'h7FFF_FFFF, 32'h8000_0000, "R7 hsub s32 rnd");
        step(1, 3, 1, 1, 0, 1, 32'h7FFF_8000, 32'h7FFF_8000, "R7 hadd s16");
        // R8 undefined codes: zero, no flag
        step(1, 5, 0, 1, 1, 0, 32'h8080_8080, 32'h8080_8080, "R8 op5");
        step(1, 7, 2, 0, 0, 0, 32'hFFFF_FFFF, 32'h1, "R8 op7");
        // R9 hold with valid low
        step(1, 0, 0, 0, 0, 0, 32'h0102_0304, 32'h1010_1010, "R1 add u8 no ovf");
        step(0, 0, 0, 0, 0, 0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, "R9 idle hold");
        // R1 lane isolation, no flag
        step(1, 0, 1, 0, 0, 0, 32'h0000_FFFF, 32'h0000_0000, "R1 add u16 edge");
        step(1, 1, 3, 0, 0, 0, 32'h0001_0000, 32'h0000_0001, "R1 sub word lane3");
        // first overflow: R4 wrap sets flag
        step(1, 0, 0, 0, 0, 0, 32'hFF01_0203, 32'h0201_0203, "R4 add u8 wrap");
        step(1, 0, 0, 0, 1, 0, 32'hFF01_80F0, 32'h0201_8020, "R3 add u8 sat");
        step(1, 1, 1, 0, 1, 0, 32'h0001_0005, 32'h0002_0003, "R3 sub u16 sat");
        step(1, 0, 1, 1, 1, 0, 32'h7000_9000, 32'h2000_9000, "R2 add s16 sat");
        step(1, 1, 2, 1, 1, 0, 32'h8000_0000, 32'h0000_0001, "R2 sub s32 sat");
        step(1, 1, 2, 1, 1, 0, 32'h0000_0000, 32'h8000_0000, "R2 sub s32 sat pos");
        step(1, 1, 0, 1, 0, 0, 32'h807F_0000, 32'h01FF_0000, "R4 sub s8 wrap");
        step(1, 2, 0, 0, 1, 0, 32'h8081_FF7F, 32'h1234_5678, "R5 abs s8 sat");
        step(1, 2, 1, 1, 0, 0, 32'h8000_FFFE, 32'h0, "R5 abs s16 wrap");
        step(1, 2, 2, 1, 1, 0, 32'h8000_0000, 32'h0, "R5 abs s32 sat");
        step(0, 1, 0, 0, 0, 0, 32'h0, 32'h0, "R6 sticky idle");
        step(1, 0, 2, 0, 0, 0, 32'h1, 32'h1, "R6 sticky after clean op");
        do_reset("R9 reset clears sticky");
        step(1, 2, 2, 1, 1, 0, 32'h8000_0001, 32'h0, "R5 abs no ovf");
        for (int i = 0; i < 600; i++) begin
            int op = $urandom_range(0, 7);
            step(($urandom_range(0, 3) != 0), op, $urandom_range(0, 3),
                 1'($urandom), 1'($urandom), 1'($urandom),
                 $urandom, $urandom, "R1 R2 R3 R4 R5 R6 R7 R8 random");
        end
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule